// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Controller with Level-Match Interrupts

This block sits between a simple word-addressed register bus and a row of bidirectional pads. Software picks, pin by pin, whether a pad is ordinary GPIO or is lent to an alternate peripheral. A GPIO pin can be an input or an output. The block holds the value driven on output pins and reads back the state of every pad. Each pin can be armed to raise a sticky interrupt flag whenever its level equals a programmed value.

Pad inputs pass through a two-stage synchronizer before anything uses them. That synchronized value feeds the data readback, the level compare and the alternate-function inputs. When a pin is lent to a peripheral, its direction comes from a fixed per-pin mask given at build time, not from the direction register. Two interrupt lines leave the block: an ordinary one, raised when any status flag is set, and a non-maskable one, which only the flags enabled in a separate register can raise.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is high and after it, every register reads 0, no pad is driven (pad_oe = 0) and irq and nmi are low until a status bit sets.
- R2: Registers sit at word offsets 0 (function select), 1 (direction), 2 (data), 3 (match level), 4 (interrupt status), 5 (NMI enable). Bit n of each register belongs to pin n. Function select, direction, match level and NMI enable read back exactly what was last written.
- R3: Offsets 6 and 7 read as 0, and writes to them change no register.
- R4: A pin with function bit 0 and direction bit 1 drives the written data bit (pad_oe = 1, pad_out = data bit). With direction bit 0 it is not driven.
- R5: Reading offset 2 returns the pad input delayed by exactly two clock edges. Written output values appear there only through the pad.
- R6: A pin with function bit 1 takes its direction from build mask ALT_OUT_MASK, default 0x000021F5: pins 0, 2, 4 to 8 and 13 are outputs, and the rest are inputs. An output pin drives alt_out[n]. An input pin passes its synchronized pad value to alt_in[n]. In every other case alt_in[n] is 0.
- R7: A status bit sets in the cycle after the synchronized pin value equals its match-level bit. It stays set after the pin stops matching.
- R8: Writing the status register clears each bit written as 0. Bits written as 1 keep their value.
- R9: If a pin still matches in the cycle its status bit is written 0, the bit stays set.
- R10: irq is the OR of all status bits. nmi is the OR of the status bits that are also set in the NMI enable register. Both follow the status register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Pad input values |
| pad_out | output | 32 | Values driven on the pads |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Outputs from the alternate peripherals |
| alt_in | output | 32 | Synchronized inputs to the alternate peripherals |
| irq | output | 1 | Ordinary interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
A register write lands on the clock edge where bus_wr is sampled, so the pad outputs, irq and nmi are checked at the following falling edge. Pad changes reach the data readback two edges later. The bench samples this readback after one edge, expecting the old value, and again after the second edge, expecting the new one. Status bits lag the synchronized value by one more edge, so the bench waits at least four edges before it reads status after changing a pad or the match level. All reads are combinational and are sampled 1 ns after a falling edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W  = 32;
    localparam int OFS_W  = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_FUNC  = 3'd0,
        OFS_DIR   = 3'd1,
        OFS_DATA  = 3'd2,
        OFS_LEVEL = 3'd3,
        OFS_STAT  = 3'd4,
        OFS_NMIEN = 3'd5
    } gpio_ofs_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [OFS_W-1:0]  ofs;
    } bus_req_t;

    // Status update: clear bits written 0, hold bits written 1, new matches win.
    function automatic logic [BUS_W-1:0] stat_next(
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] keep_mask,
        input logic             do_write,
        input logic [BUS_W-1:0] hits
    );
        logic [BUS_W-1:0] held;
        held = do_write ? (cur & keep_mask) : cur;
        return held | hits;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [NUM_PINS-1:0]  sync_in,
    input  logic [NUM_PINS-1:0]  stat_in,
    output logic [NUM_PINS-1:0]  func_q,
    output logic [NUM_PINS-1:0]  dir_q,
    output logic [NUM_PINS-1:0]  dout_q,
    output logic [NUM_PINS-1:0]  level_q,
    output logic [NUM_PINS-1:0]  nmien_q,
    output logic                 stat_wr,
    output logic [BUS_W-1:0]     rdata
);
    logic [NUM_PINS-1:0] wbits;
    assign wbits   = wdata[NUM_PINS-1:0];
    assign stat_wr = req.wr && (req.ofs == OFS_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            level_q <= '0;
            nmien_q <= '0;
        end else if (req.wr) begin
            case (req.ofs)
                OFS_FUNC:  func_q  <= wbits;
                OFS_DIR:   dir_q   <= wbits;
                OFS_DATA:  dout_q  <= wbits;
                OFS_LEVEL: level_q <= wbits;
                OFS_NMIEN: nmien_q <= wbits;
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.ofs)
                OFS_FUNC:  rdata[NUM_PINS-1:0] = func_q;
                OFS_DIR:   rdata[NUM_PINS-1:0] = dir_q;
                OFS_DATA:  rdata[NUM_PINS-1:0] = sync_in;
                OFS_LEVEL: rdata[NUM_PINS-1:0] = level_q;
                OFS_STAT:  rdata[NUM_PINS-1:0] = stat_in;
                OFS_NMIEN: rdata[NUM_PINS-1:0] = nmien_q;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int               NUM_PINS     = 32,
    parameter logic [BUS_W-1:0] ALT_OUT_MASK = 32'h0000_21F5
) (
    input  logic [NUM_PINS-1:0] func_q,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] dout_q,
    input  logic [NUM_PINS-1:0] sync_in,
    input  logic [NUM_PINS-1:0] alt_out,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] alt_in
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam logic ALT_IS_OUT = ALT_OUT_MASK[n];
        if (ALT_IS_OUT) begin : g_alt_out
            assign pad_oe[n]  = func_q[n] ? 1'b1 : dir_q[n];
            assign pad_out[n] = func_q[n] ? alt_out[n] : dout_q[n];
            assign alt_in[n]  = 1'b0;
        end else begin : g_alt_in
            assign pad_oe[n]  = func_q[n] ? 1'b0 : dir_q[n];
            assign pad_out[n] = func_q[n] ? alt_out[n] : dout_q[n];
            assign alt_in[n]  = func_q[n] & sync_in[n];
        end
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] sync_in,
    input  logic [NUM_PINS-1:0] level_q,
    input  logic [NUM_PINS-1:0] nmien_q,
    input  logic                stat_wr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] stat_q,
    output logic                irq,
    output logic                nmi
);
    logic [NUM_PINS-1:0] hits;
    logic [BUS_W-1:0]    cur_w, hits_w, nxt_w;

    assign hits = ~(sync_in ^ level_q);

    always_comb begin
        cur_w  = '0;
        hits_w = '0;
        cur_w[NUM_PINS-1:0]  = stat_q;
        hits_w[NUM_PINS-1:0] = hits;
        nxt_w = stat_next(cur_w, wdata, stat_wr, hits_w);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= nxt_w[NUM_PINS-1:0];
    end

    assign irq = |stat_q;
    assign nmi = |(stat_q & nmien_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int               NUM_PINS     = 32,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [BUS_W-1:0] ALT_OUT_MASK = 32'h0000_21F5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [OFS_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    input  logic [NUM_PINS-1:0]  alt_out,
    output logic [NUM_PINS-1:0]  alt_in,
    output logic                 irq,
    output logic                 nmi
);
    bus_req_t            req;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] func_q, dir_q, dout_q, level_q, nmien_q, stat_q;
    logic                stat_wr;

    assign req.wr  = bus_sel & bus_wr;
    assign req.rd  = bus_sel & ~bus_wr;
    assign req.ofs = bus_addr;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(sync_q)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .req(req), .wdata(bus_wdata),
        .sync_in(sync_q), .stat_in(stat_q),
        .func_q(func_q), .dir_q(dir_q), .dout_q(dout_q),
        .level_q(level_q), .nmien_q(nmien_q),
        .stat_wr(stat_wr), .rdata(bus_rdata)
    );

    gpio_pinmux #(.NUM_PINS(NUM_PINS), .ALT_OUT_MASK(ALT_OUT_MASK)) u_mux (
        .func_q(func_q), .dir_q(dir_q), .dout_q(dout_q), .sync_in(sync_q),
        .alt_out(alt_out), .pad_out(pad_out), .pad_oe(pad_oe), .alt_in(alt_in)
    );

    gpio_irq #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk(clk), .rst(rst), .sync_in(sync_q), .level_q(level_q),
        .nmien_q(nmien_q), .stat_wr(stat_wr), .wdata(bus_wdata),
        .stat_q(stat_q), .irq(irq), .nmi(nmi)
    );
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [2:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] sync_q,
    input logic [NUM_PINS-1:0] level_q,
    input logic [NUM_PINS-1:0] stat_q,
    input logic                irq,
    input logic                nmi
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)           cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    logic stat_write;
    assign stat_write = bus_sel && bus_wr && (bus_addr == 3'd4);

    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr > 3'd5) |-> (bus_rdata == 32'd0));

    p_sync_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (sync_q == $past(pad_in, 2)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!stat_write && cyc >= 2'd1) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_match_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1) |=> ((stat_q | $past(sync_q ^ level_q)) == {NUM_PINS{1'b1}}));

    p_clear_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_write && cyc >= 2'd1) |=>
        ((stat_q & ~($past(stat_q & bus_wdata[NUM_PINS-1:0]) | ~$past(sync_q ^ level_q)))
         == {NUM_PINS{1'b0}}));

    p_nmi_implies_irq_r10: assert property (@(posedge clk) disable iff (rst)
        nmi |-> irq);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .sync_q(sync_q), .level_q(level_q),
    .stat_q(stat_q), .irq(irq), .nmi(nmi)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb_top;
    localparam logic [31:0] ALT_MASK = 32'h0000_21F5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in, pad_out, pad_oe, alt_in;
    logic [31:0] alt_out = '0;
    logic [31:0] ext_drv = '0;
    logic        irq, nmi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv);

    gpio_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_in(alt_in), .irq(irq), .nmi(nmi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ofs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] ofs, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ofs;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] pat;

        // R1: reset state, sampled while reset is still high
        repeat (3) @(negedge clk);
        for (int o = 0; o < 6; o++) begin
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(o);
            #1 chk("R1 reset readback", bus_rdata, 32'd0);
            @(negedge clk);
        end
        bus_sel = 1'b0;
        chk("R1 reset pad_oe", pad_oe, 32'd0);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset nmi", {31'd0, nmi}, 32'd0);
        rst = 1'b0;

        // R2: walking-one and pattern sweep on the plain read/write registers
        for (int o = 0; o < 6; o++) begin
            if (o == 2 || o == 4) continue;
            for (int i = 0; i < 33; i++) begin
                pat = (i == 32) ? 32'hA5C3_5A3C : (32'd1 << i);
                wr_reg(3'(o), pat);
                rd_reg(3'(o), r);
                chk("R2 register readback", r, pat);
            end
        end

        // R3: unmapped offsets ignore writes and read zero
        wr_reg(3'd0, 32'h1111_0000);
        wr_reg(3'd1, 32'h2222_0000);
        wr_reg(3'd3, 32'h3333_0000);
        wr_reg(3'd5, 32'h4444_0000);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd_reg(3'd6, r); chk("R3 offset 6 reads zero", r, 32'd0);
        rd_reg(3'd7, r); chk("R3 offset 7 reads zero", r, 32'd0);
        rd_reg(3'd0, r); chk("R3 func unchanged", r, 32'h1111_0000);
        rd_reg(3'd1, r); chk("R3 dir unchanged", r, 32'h2222_0000);
        rd_reg(3'd3, r); chk("R3 level unchanged", r, 32'h3333_0000);
        rd_reg(3'd5, r); chk("R3 nmien unchanged", r, 32'h4444_0000);

        // R4: GPIO outputs drive data, loop back through the pad
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd5, 32'd0);
        wr_reg(3'd1, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) begin
            pat = 32'h9E37_79B9 * (k + 1);
            wr_reg(3'd2, pat);
            chk("R4 pad_oe all outputs", pad_oe, 32'hFFFF_FFFF);
            chk("R4 pad_out follows data", pad_out, pat);
            wait_cyc(2);
            rd_reg(3'd2, r);
            chk("R4 output loopback readback", r, pat);
        end
        wr_reg(3'd1, 32'h0000_FFFF);
        chk("R4 inputs not driven", pad_oe, 32'h0000_FFFF);

        // R5: input path takes exactly two edges
        wr_reg(3'd1, 32'd0);
        ext_drv = 32'h0000_0000;
        wait_cyc(3);
        for (int k = 0; k < 3; k++) begin
            pat = 32'hC001_D00D ^ (32'h0101_0101 << k);
            @(negedge clk);
            ext_drv = pat;
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
            @(negedge clk);
            #1 chk("R5 readback not yet updated after one edge", bus_rdata, (k == 0) ? 32'd0 : (32'hC001_D00D ^ (32'h0101_0101 << (k - 1))));
            @(negedge clk);
            #1 chk("R5 readback updated after two edges", bus_rdata, pat);
            bus_sel = 1'b0;
        end

        // R6: alternate-function direction, output and input routing
        alt_out = 32'h5555_AAAA;
        ext_drv = 32'hF0F0_3C3C;
        wr_reg(3'd0, 32'hFFFF_FFFF);
        chk("R6 alt pad_oe mask", pad_oe, ALT_MASK);
        chk("R6 alt pad_out", pad_out & ALT_MASK, alt_out & ALT_MASK);
        wait_cyc(3);
        chk("R6 alt_in inputs", alt_in, ext_drv & ~ALT_MASK);
        wr_reg(3'd1, 32'hFFFF_0000);
        wr_reg(3'd2, 32'h1234_0000);
        wr_reg(3'd0, 32'h0000_FFFF);
        chk("R6 mixed pad_oe", pad_oe, (ALT_MASK & 32'h0000_FFFF) | 32'hFFFF_0000);
        chk("R6 mixed pad_out", pad_out & pad_oe,
            ((alt_out & ALT_MASK) & 32'h0000_FFFF) | 32'h1234_0000);
        wait_cyc(3);
        chk("R6 mixed alt_in", alt_in, ext_drv & ~ALT_MASK & 32'h0000_FFFF);
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd1, 32'd0);
        chk("R6 gpio mode alt_in zero", alt_in, 32'd0);

        // R7: match sets status, status is sticky
        ext_drv = 32'd0;
        wr_reg(3'd3, 32'hFFFF_FFFF);
        wait_cyc(4);
        wr_reg(3'd4, 32'd0);
        wait_cyc(1);
        rd_reg(3'd4, r); chk("R8 clear all", r, 32'd0);
        chk("R10 irq low when clear", {31'd0, irq}, 32'd0);
        pat = 32'h00A5_1C03;
        ext_drv = pat;
        wait_cyc(4);
        rd_reg(3'd4, r); chk("R7 match sets status", r, pat);
        chk("R10 irq high", {31'd0, irq}, 32'd1);
        ext_drv = 32'd0;
        wait_cyc(4);
        rd_reg(3'd4, r); chk("R7 status sticky", r, pat);

        // R8: write 0 clears, write 1 keeps
        wr_reg(3'd4, ~32'h0000_0C01);
        rd_reg(3'd4, r); chk("R8 partial clear", r, 32'h00A5_1002);

        // R10: nmi masking
        wr_reg(3'd5, 32'd0);
        chk("R10 nmi disabled", {31'd0, nmi}, 32'd0);
        wr_reg(3'd5, 32'h0000_0002);
        chk("R10 nmi enabled bit set", {31'd0, nmi}, 32'd1);
        wr_reg(3'd5, 32'h0000_0001);
        chk("R10 nmi enabled bit clear", {31'd0, nmi}, 32'd0);
        chk("R10 irq still high", {31'd0, irq}, 32'd1);

        // R9: set wins over a simultaneous clear
        ext_drv = 32'h0010_0000;
        wait_cyc(4);
        wr_reg(3'd4, 32'd0);
        rd_reg(3'd4, r); chk("R9 set beats clear", r, 32'h0010_0000);

        // R7: match against level 0
        wr_reg(3'd3, 32'd0);
        ext_drv = 32'hFFFF_FFFF;
        wait_cyc(4);
        wr_reg(3'd4, 32'd0);
        rd_reg(3'd4, r); chk("R7 level0 no match", r, 32'd0);
        ext_drv = 32'hFFFF_FF00;
        wait_cyc(4);
        rd_reg(3'd4, r); chk("R7 level0 match", r, 32'h0000_00FF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule